// File: doc/BRIEF.md
# Serial Command Front End for a 64-Step Digital Potentiometer

This block is the serial slave interface that sits in front of a wiper position register and a bank of four stored settings of a 64-step digital potentiometer. It runs on the chip's system clock and oversamples the serial pins. Data is taken from SI on each rising SCK edge, and SO changes only on falling SCK edges. Each command opens with an identity byte. That byte carries a fixed type field and one bit that must match a pin-strapped address input. An instruction byte follows, and then, depending on the instruction, either one data byte, nothing more, or an open-ended run of single-step wiper moves.

The block does not hold the wiper value or the stored settings. Instead it issues one-cycle requests to a neighbouring register block and store sequencer. Read data comes back through combinational inputs: the wiper value, the stored setting selected by `dr_sel`, and a write-in-progress flag. Requests that change a register are held until chip select rises after a fully received command. A command cut short therefore changes nothing. A hold input can freeze a transfer part-way through and resume it later.

Top module: `potcmd_spi`

## Requirements
- R1: After reset no command is decoded until a high-to-low transition of `cs_n` has been observed; a command clocked in while `cs_n` was already low at reset produces no request.
- R2: The first byte after `cs_n` falls must equal {4'b0101, 3'b110, addr_pin}, MSB first; on any mismatch the rest of the selection is ignored: no request is issued and `so_en` stays low.
- R3: The second byte is {op[3:0], sel[1:0], 2'b00}. Accepted bytes: op 1001 and 1010 with the low nibble 0000, op 1011, 1100, 1101 and 1110 with any sel, the exact byte 0010_0000 and the exact byte 0101_0001. Any other byte makes the block ignore the rest of the selection.
- R4: Read commands (1001 wiper value, 1011 stored setting chosen by sel, 0101_0001 status) return a third byte on `so`, MSB first. For the wiper and setting reads the byte is {2'b00, value[5:0]}; for status it is {7'b0, wip}. The first bit appears after the falling SCK that follows the instruction byte, and `so` changes only after falling SCK edges.
- R5: Write commands (1010 wiper, 1100 stored setting) take a third byte whose low six bits are the data. The request (req_kind 1 for the wiper, 2 for a setting, carrying req_sel and req_data) is issued only when `cs_n` rises after all 24 bits.
- R6: Transfer commands end after the instruction byte. 1101 copies a setting into the wiper (req_kind 3) and 1110 copies the wiper into a setting (req_kind 4), each with req_sel equal to sel, issued when `cs_n` rises.
- R7: After byte 0010_0000, each rising SCK while selected issues a step request: req_kind 5 (toward the high end) if SI is 1, req_kind 6 (toward the low end) if SI is 0. This continues until `cs_n` rises.
- R8: `so_en` is high only during the data byte of a read command, with `cs_n` low and no hold pause; otherwise `so` is undriven, including after reset and whenever `cs_n` is high.
- R9: Driving `hold_n` low while SCK is low pauses the transfer: SCK edges are ignored and `so_en` drops. Driving `hold_n` high while SCK is low resumes the command with no bits lost.
- R10: If `cs_n` rises before a command's last bit, no request is issued.
- R11: Every request is a single-cycle pulse of `req_vld`, and exactly one pulse is issued per completed register-changing command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Active-low pause of the serial transfer |
| addr_pin | input | 1 | Strapped address bit compared with the identity byte LSB |
| so | output | 1 | Serial data out |
| so_en | output | 1 | Drive enable for `so`; low means high impedance |
| dr_sel | output | 2 | Stored-setting index presented to the register block |
| wiper_val | input | 6 | Current wiper value from the register block |
| dr_val | input | 6 | Stored setting selected by `dr_sel` |
| wip | input | 1 | Store-in-progress flag from the store sequencer |
| req_vld | output | 1 | One-cycle request strobe |
| req_kind | output | 3 | Request code: 1 write wiper, 2 write setting, 3 setting to wiper, 4 wiper to setting, 5 step up, 6 step down |
| req_sel | output | 2 | Stored-setting index for the request |
| req_data | output | 6 | Data for write requests |

## Verification
The assertions check several properties on every cycle. Request pulses never last more than one cycle. Register-changing requests only appear once chip select is high. Each step request agrees with the SI level and the SCK rise that caused it. SO never moves while SCK was high. The bench's scenarios are needed for what depends on a whole byte sequence: rejection of a wrong identity or opcode, the byte values returned by reads, the capture of write data, the discard of aborted commands, the lockout before the first select, and the hold pause resuming with no bit lost.

// File: rtl/potcmd_pkg.sv
package potcmd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_ID, ST_INSTR, ST_DIN, ST_DOUT, ST_STEP, ST_DONE, ST_IGNORE
    } st_e;

    typedef enum logic [3:0] {
        C_BAD, C_RD_WCR, C_WR_WCR, C_RD_DR, C_WR_DR, C_D2W, C_W2D, C_STEP, C_STAT
    } cmd_e;

    typedef enum logic [2:0] {
        K_NONE = 3'd0, K_WR_WCR = 3'd1, K_WR_DR = 3'd2, K_D2W = 3'd3,
        K_W2D = 3'd4, K_UP = 3'd5, K_DN = 3'd6
    } kind_e;

    typedef enum logic [1:0] {SRC_WCR, SRC_DR, SRC_STAT} src_e;
endpackage

// File: rtl/potcmd_edges.sv
module potcmd_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic hold_n,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_fall,
    output logic cs_rise,
    output logic paused
);
    logic sck_q, cs_q, pause_q;
    logic pause_d;

    always_comb begin
        pause_d = pause_q;
        if (cs_n)
            pause_d = 1'b0;
        else if (!sck && !sck_q)
            pause_d = !hold_n;   // pause state only changes while SCK is low
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q   <= 1'b0;
            cs_q    <= 1'b0;     // low so a select held at reset is no edge
            pause_q <= 1'b0;
        end else begin
            sck_q   <= sck;
            cs_q    <= cs_n;
            pause_q <= pause_d;
        end
    end

    assign sck_rise = !cs_n && !pause_q &&  sck && !sck_q;
    assign sck_fall = !cs_n && !pause_q && !sck &&  sck_q;
    assign cs_fall  = !cs_n &&  cs_q;
    assign cs_rise  =  cs_n && !cs_q;
    assign paused   = pause_q;
endmodule

// File: rtl/potcmd_decode.sv
module potcmd_decode
    import potcmd_pkg::*;
(
    input  logic [7:0] ibyte,
    output cmd_e       cmd,
    output logic [1:0] sel
);
    localparam logic [3:0] OP_RD_WCR = 4'b1001;
    localparam logic [3:0] OP_WR_WCR = 4'b1010;
    localparam logic [3:0] OP_RD_DR  = 4'b1011;
    localparam logic [3:0] OP_WR_DR  = 4'b1100;
    localparam logic [3:0] OP_D2W    = 4'b1101;
    localparam logic [3:0] OP_W2D    = 4'b1110;
    localparam logic [7:0] B_STEP    = 8'b0010_0000;
    localparam logic [7:0] B_STAT    = 8'b0101_0001;

    logic tail_ok;
    assign tail_ok = (ibyte[1:0] == 2'b00);
    assign sel     = ibyte[3:2];

    always_comb begin
        cmd = C_BAD;
        if (ibyte == B_STEP)
            cmd = C_STEP;
        else if (ibyte == B_STAT)
            cmd = C_STAT;
        else if (tail_ok) begin
            unique case (ibyte[7:4])
                OP_RD_WCR: if (ibyte[3:2] == 2'b00) cmd = C_RD_WCR;
                OP_WR_WCR: if (ibyte[3:2] == 2'b00) cmd = C_WR_WCR;
                OP_RD_DR:  cmd = C_RD_DR;
                OP_WR_DR:  cmd = C_WR_DR;
                OP_D2W:    cmd = C_D2W;
                OP_W2D:    cmd = C_W2D;
                default:   cmd = C_BAD;
            endcase
        end
    end
endmodule

// File: rtl/potcmd_spi.sv
module potcmd_spi
    import potcmd_pkg::*;
#(
    parameter int          DW       = 6,
    parameter logic [3:0]  ID_TYPE  = 4'b0101,
    parameter logic [2:0]  ID_FIXED = 3'b110
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          sck,
    input  logic          si,
    input  logic          hold_n,
    input  logic          addr_pin,
    output logic          so,
    output logic          so_en,
    output logic [1:0]    dr_sel,
    input  logic [DW-1:0] wiper_val,
    input  logic [DW-1:0] dr_val,
    input  logic          wip,
    output logic          req_vld,
    output logic [2:0]    req_kind,
    output logic [1:0]    req_sel,
    output logic [DW-1:0] req_data
);
    localparam int BW = 8;
    localparam int CW = $clog2(BW);
    localparam logic [CW-1:0] LAST = CW'(BW - 1);

    typedef struct packed {
        st_e           st;
        logic [CW-1:0] cnt;
        logic [BW-2:0] sr;
        kind_e         kind;
        logic [1:0]    sel;
        logic [DW-1:0] data;
        src_e          src;
        logic [BW-1:0] tx;
        logic          so;
        logic          loaded;
        logic          vld;
        kind_e         rkind;
        logic [1:0]    rsel;
        logic [DW-1:0] rdata;
    } st_t;

    st_t q, d;

    logic sck_rise, sck_fall, cs_fall, cs_rise, paused;
    logic [BW-1:0] byte_in, rd_byte, out_b;
    cmd_e dcmd;
    logic [1:0] dsel;

    potcmd_edges u_edges (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .hold_n(hold_n),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_fall(cs_fall),
        .cs_rise(cs_rise), .paused(paused)
    );

    assign byte_in = {q.sr, si};

    potcmd_decode u_dec (.ibyte(byte_in), .cmd(dcmd), .sel(dsel));

    always_comb begin
        unique case (q.src)
            SRC_WCR: rd_byte = {{(BW-DW){1'b0}}, wiper_val};
            SRC_DR:  rd_byte = {{(BW-DW){1'b0}}, dr_val};
            default: rd_byte = {{(BW-1){1'b0}}, wip};
        endcase
        out_b = q.loaded ? q.tx : rd_byte;
    end

    always_comb begin
        d     = q;
        d.vld = 1'b0;
        if (cs_rise) begin
            if (q.st == ST_DONE && q.kind != K_NONE) begin
                d.vld   = 1'b1;
                d.rkind = q.kind;
                d.rsel  = q.sel;
                d.rdata = q.data;
            end
            d.st   = ST_IDLE;
            d.kind = K_NONE;
        end else if (cs_fall) begin
            d.st     = ST_ID;
            d.cnt    = '0;
            d.kind   = K_NONE;
            d.loaded = 1'b0;
        end else if (sck_rise) begin
            d.sr  = byte_in[BW-2:0];
            d.cnt = q.cnt + CW'(1);
            unique case (q.st)
                ST_ID: if (q.cnt == LAST)
                    d.st = (byte_in == {ID_TYPE, ID_FIXED, addr_pin}) ? ST_INSTR : ST_IGNORE;
                ST_INSTR: if (q.cnt == LAST) begin
                    d.sel    = dsel;
                    d.loaded = 1'b0;
                    unique case (dcmd)
                        C_RD_WCR: begin d.st = ST_DOUT; d.src = SRC_WCR;  end
                        C_RD_DR:  begin d.st = ST_DOUT; d.src = SRC_DR;   end
                        C_STAT:   begin d.st = ST_DOUT; d.src = SRC_STAT; end
                        C_WR_WCR: begin d.st = ST_DIN;  d.kind = K_WR_WCR; end
                        C_WR_DR:  begin d.st = ST_DIN;  d.kind = K_WR_DR;  end
                        C_D2W:    begin d.st = ST_DONE; d.kind = K_D2W;    end
                        C_W2D:    begin d.st = ST_DONE; d.kind = K_W2D;    end
                        C_STEP:   d.st = ST_STEP;
                        default:  d.st = ST_IGNORE;
                    endcase
                end
                ST_DIN: if (q.cnt == LAST) begin
                    d.data = byte_in[DW-1:0];
                    d.st   = ST_DONE;
                end
                ST_DOUT: if (q.cnt == LAST) d.st = ST_DONE;
                ST_STEP: begin
                    d.vld   = 1'b1;
                    d.rkind = si ? K_UP : K_DN;
                    d.rsel  = q.sel;
                    d.rdata = q.data;
                end
                default: ;
            endcase
        end else if (sck_fall && q.st == ST_DOUT) begin
            d.so     = out_b[BW-1];
            d.tx     = {out_b[BW-2:0], 1'b0};
            d.loaded = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign so       = q.so;
    assign so_en    = (q.st == ST_DOUT) && !cs_n && !paused;
    assign dr_sel   = q.sel;
    assign req_vld  = q.vld;
    assign req_kind = q.rkind;
    assign req_sel  = q.rsel;
    assign req_data = q.rdata;
endmodule

// File: rtl/potcmd_chk.sv
module potcmd_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       sck,
    input logic       si,
    input logic       so,
    input logic       so_en,
    input logic       req_vld,
    input logic [2:0] req_kind
);
    AST_REQ_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld |=> !req_vld); // R11

    AST_REQ_KIND_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld |-> (req_kind != 3'd0 && req_kind <= 3'd6)); // R11

    AST_STORE_AFTER_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && req_kind >= 3'd1 && req_kind <= 3'd4) |-> (cs_n && $past(cs_n))); // R5

    AST_STEP_UP_SI_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && req_kind == 3'd5) |-> ($past(si) && $past(sck) && !$past(cs_n))); // R7

    AST_STEP_DN_SI_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && req_kind == 3'd6) |-> (!$past(si) && $past(sck) && !$past(cs_n))); // R7

    AST_SO_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (so_en && $past(so_en) && $past(sck)) |-> $stable(so)); // R4
endmodule

bind potcmd_spi potcmd_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .so(so),
    .so_en(so_en), .req_vld(req_vld), .req_kind(req_kind)
);

// File: tb/potcmd_spi_test.sv
module potcmd_spi_test;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n, cs_n, sck, si, hold_n, addr_pin, wip;
    logic so, so_en, req_vld;
    logic [1:0] dr_sel, req_sel;
    logic [2:0] req_kind;
    logic [5:0] wiper_val, dr_val, req_data;
    logic [5:0] drs [4];

    assign dr_val = drs[dr_sel];

    potcmd_spi uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
        .hold_n(hold_n), .addr_pin(addr_pin), .so(so), .so_en(so_en),
        .dr_sel(dr_sel), .wiper_val(wiper_val), .dr_val(dr_val), .wip(wip),
        .req_vld(req_vld), .req_kind(req_kind), .req_sel(req_sel),
        .req_data(req_data)
    );

    int checks = 0, fails = 0;
    int nreq = 0, en_cnt = 0;
    logic [2:0] lk;
    logic [1:0] lsel;
    logic [5:0] ldata;
    logic [2:0] klog [8];
    bit finished = 0;

    always @(negedge clk) begin
        if (rst_n && req_vld) begin
            klog[nreq % 8] = req_kind;
            lk    = req_kind;
            lsel  = req_sel;
            ldata = req_data;
            nreq++;
        end
        if (rst_n && so_en) en_cnt++;
    end

    localparam logic [7:0] ID_OK = 8'h5D;  // 0101_110 + addr_pin=1

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic half();
        repeat (4) @(negedge clk);
    endtask

    task automatic bitx(input logic b, output logic o);
        si = b;
        half();
        o = so;
        sck = 1'b1;
        half();
        sck = 1'b0;
    endtask

    task automatic xbyte(input logic [7:0] b, output logic [7:0] r);
        for (int i = 7; i >= 0; i--) begin
            logic o;
            bitx(b[i], o);
            r[i] = o;
        end
    endtask

    task automatic sel_on();
        cs_n = 1'b1; half(); cs_n = 1'b0; half();
    endtask

    task automatic sel_off();
        half(); cs_n = 1'b1; repeat (6) @(negedge clk);
    endtask

    task automatic t_reset();
        chk(so_en == 1'b0, "R8 reset so_en", so_en, 0);
        chk(req_vld == 1'b0, "R11 reset req_vld", req_vld, 0);
    endtask

    task automatic t_powerup();
        logic [7:0] r;
        int n0 = nreq;
        xbyte(ID_OK, r); xbyte(8'hA0, r); xbyte(8'h2A, r);
        cs_n = 1'b1; repeat (6) @(negedge clk);
        chk(nreq == n0, "R1 no command before first select edge", nreq - n0, 0);
    endtask

    task automatic t_writes();
        logic [7:0] r;
        int n0 = nreq;
        sel_on(); xbyte(ID_OK, r); xbyte(8'hA0, r); xbyte(8'h2A, r);
        half();
        chk(nreq == n0, "R5 no request before deselect", nreq - n0, 0);
        sel_off();
        chk(nreq == n0 + 1, "R11 one pulse per write", nreq - n0, 1);
        chk(lk == 3'd1 && ldata == 6'h2A, "R5 wiper write", {lk, ldata}, {3'd1, 6'h2A});
        n0 = nreq;
        sel_on(); xbyte(ID_OK, r); xbyte(8'hC8, r); xbyte(8'hD5, r); sel_off();
        chk(nreq == n0 + 1, "R11 one pulse per setting write", nreq - n0, 1);
        chk(lk == 3'd2 && lsel == 2'd2 && ldata == 6'h15, "R5 setting write",
            {lk, lsel, ldata}, {3'd2, 2'd2, 6'h15});
    endtask

    task automatic t_reads();
        logic [7:0] r;
        int e0;
        e0 = en_cnt;
        sel_on(); xbyte(ID_OK, r); xbyte(8'h90, r); xbyte(8'h00, r); sel_off();
        chk(r == 8'h33, "R4 wiper read", r, 8'h33);
        chk(en_cnt > e0, "R8 so driven in read", en_cnt - e0, 1);
        chk(so_en == 1'b0, "R8 so released after deselect", so_en, 0);
        sel_on(); xbyte(ID_OK, r); xbyte(8'hBC, r); xbyte(8'h00, r); sel_off();
        chk(r == 8'h0F, "R4 setting 3 read", r, 8'h0F);
        wip = 1'b1;
        sel_on(); xbyte(ID_OK, r); xbyte(8'h51, r); xbyte(8'h00, r); sel_off();
        chk(r == 8'h01, "R4 status read", r, 8'h01);
        wip = 1'b0;
    endtask

    task automatic t_xfer();
        logic [7:0] r;
        int n0 = nreq;
        sel_on(); xbyte(ID_OK, r); xbyte(8'hD4, r); sel_off();
        chk(nreq == n0 + 1 && lk == 3'd3 && lsel == 2'd1, "R6 setting to wiper",
            {lk, lsel}, {3'd3, 2'd1});
        n0 = nreq;
        sel_on(); xbyte(ID_OK, r); xbyte(8'hEC, r); sel_off();
        chk(nreq == n0 + 1 && lk == 3'd4 && lsel == 2'd3, "R6 wiper to setting",
            {lk, lsel}, {3'd4, 2'd3});
    endtask

    task automatic t_badid();
        logic [7:0] r;
        int n0 = nreq, e0 = en_cnt;
        sel_on(); xbyte(8'h5C, r); xbyte(8'h90, r); xbyte(8'h00, r); sel_off();
        chk(en_cnt == e0, "R2 address bit mismatch keeps so off", en_cnt - e0, 0);
        sel_on(); xbyte(8'h4D, r); xbyte(8'hA0, r); xbyte(8'h2A, r); sel_off();
        chk(nreq == n0, "R2 type mismatch issues nothing", nreq - n0, 0);
    endtask

    task automatic t_badop();
        logic [7:0] r;
        int n0 = nreq, e0 = en_cnt;
        sel_on(); xbyte(ID_OK, r); xbyte(8'h00, r); xbyte(8'h11, r); sel_off();
        sel_on(); xbyte(ID_OK, r); xbyte(8'hD5, r); sel_off();
        chk(nreq == n0, "R3 undefined instruction ignored", nreq - n0, 0);
        sel_on(); xbyte(ID_OK, r); xbyte(8'h91, r); xbyte(8'h00, r); sel_off();
        chk(en_cnt == e0, "R3 bad read byte keeps so off", en_cnt - e0, 0);
    endtask

    task automatic t_step();
        logic [7:0] r;
        logic o;
        int n0 = nreq;
        logic [4:0] pat = 5'b11010;
        sel_on(); xbyte(ID_OK, r); xbyte(8'h20, r);
        for (int i = 4; i >= 0; i--) bitx(pat[i], o);
        sel_off();
        chk(nreq == n0 + 5, "R7 one step per pulse", nreq - n0, 5);
        for (int i = 0; i < 5; i++) begin
            logic [2:0] e = pat[4 - i] ? 3'd5 : 3'd6;
            chk(klog[(n0 + i) % 8] == e, "R7 step direction", klog[(n0 + i) % 8], e);
        end
    endtask

    task automatic t_abort();
        logic [7:0] r;
        logic o;
        int n0 = nreq;
        sel_on(); xbyte(ID_OK, r); xbyte(8'hA0, r);
        for (int i = 0; i < 5; i++) bitx(1'b1, o);
        sel_off();
        sel_on(); xbyte(ID_OK, r);
        for (int i = 0; i < 4; i++) bitx(1'b1, o);
        sel_off();
        chk(nreq == n0, "R10 aborted commands issue nothing", nreq - n0, 0);
    endtask

    task automatic t_hold();
        logic [7:0] r, rb;
        logic o;
        int n0 = nreq;
        logic [7:0] dbyte = 8'h2C;
        sel_on(); xbyte(ID_OK, r); xbyte(8'hC4, r);
        for (int i = 7; i >= 5; i--) bitx(dbyte[i], o);
        hold_n = 1'b0; half();
        for (int i = 0; i < 3; i++) bitx(1'b1, o);
        hold_n = 1'b1; half();
        for (int i = 4; i >= 0; i--) bitx(dbyte[i], o);
        sel_off();
        chk(nreq == n0 + 1 && lk == 3'd2 && lsel == 2'd1 && ldata == 6'h2C,
            "R9 write survives pause", {lk, lsel, ldata}, {3'd2, 2'd1, 6'h2C});
        sel_on(); xbyte(ID_OK, r); xbyte(8'h90, r);
        for (int i = 7; i >= 6; i--) begin bitx(1'b0, o); rb[i] = o; end
        hold_n = 1'b0; half();
        chk(so_en == 1'b0, "R9 so released during pause", so_en, 0);
        bitx(1'b0, o);
        hold_n = 1'b1; half();
        for (int i = 5; i >= 0; i--) begin bitx(1'b0, o); rb[i] = o; end
        sel_off();
        chk(rb == 8'h33, "R9 read resumes with no bit lost", rb, 8'h33);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        summary();
    end

    initial begin
        rst_n = 1'b0; cs_n = 1'b0; sck = 1'b0; si = 1'b0; hold_n = 1'b1;
        addr_pin = 1'b1; wip = 1'b0; wiper_val = 6'h33;
        drs[0] = 6'h01; drs[1] = 6'h22; drs[2] = 6'h3E; drs[3] = 6'h0F;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        half();
        t_reset();
        t_powerup();
        t_writes();
        t_reads();
        t_xfer();
        t_badid();
        t_badop();
        t_step();
        t_abort();
        t_hold();
        summary();
    end
endmodule